// File: doc/BRIEF.md
# Dual-Address I2C Slave Engine

This block is an I2C target that answers on two independent address slots, A and B. Each slot has an enable, a programmable 7-bit address, a receive register filled from the bus and a transmit register loaded by the CPU. The engine oversamples SCL and SDA with the system clock and finds START and STOP conditions. It compares the address byte against both slots and acknowledges a hit. After that it moves data bytes into the selected slot's receive register, or shifts them out of its transmit register. SDA is driven through an open-drain enable.

Slot B matches its full 7-bit address. Slot A compares only the upper five address bits, so it answers a group of four consecutive addresses. The two low bits the host actually sent are kept in status. The engine also notes whether the byte in a receive register was the first data byte of a write, which is the word address. Single-cycle event pulses tell the CPU about an address match, a newly received byte and a transmit register that has just been consumed. Combining these events into an interrupt is left to the surrounding logic.

Top module: `dual_addr_i2c_slave`

## Requirements
- R1: After reset, SDA is released, the control register (offset 0) reads 0, the status register (offset 5) reads 0, and the address registers (offsets 1 for A, 2 for B) read the reset addresses left-aligned: address in bits 7:1, bit 0 zero.
- R2: Status bit 0 (busy) sets when SDA falls while SCL is high (START) and clears when SDA rises while SCL is high (STOP).
- R3: When slot B is enabled (control bit 1), an address byte whose upper seven bits equal its address is acknowledged. SDA is pulled low during the ninth clock, and every following written byte is acknowledged, stored in the B receive register (read at offset 4) and signalled on ev_rx_b.
- R4: Slot A (enabled by control bit 0) matches when address bits 6:2 equal its own bits 6:2. The two low address bits sent by the host appear in status bits 6:5, and written bytes land in the A receive register (read at offset 3).
- R5: An address that matches no enabled slot gets no acknowledge. The following bytes are neither acknowledged nor stored, and no event is raised.
- R6: Status bit 3 (slot A) or bit 4 (slot B) reads 1 when the byte in that slot's receive register is the first data byte after a write address, and 0 after any later byte of the same transfer.
- R7: Status bit 1 holds the R/W bit of the last matched address byte: 1 for slave transmit, 0 for slave receive.
- R8: In slave transmit, the selected slot's transmit register (written at offset 3 for A, 4 for B) is sent MSB first, with SDA changing only while SCL is low. Each byte taken from the transmit register raises ev_tx_a or ev_tx_b, so the CPU can write the next byte before the host acknowledges the current one.
- R9: A NACK from the host after a transmitted byte sets status bit 2 and makes the slave release SDA until the next START, which clears that bit.
- R10: A repeated START during a transfer restarts the address phase while busy stays set.
- R11: An address hit raises one pulse on ev_match_a or ev_match_b for the slot selected. Status bit 7 shows the selected slot (1 = B).
- R12: If an address hits both enabled slots, slot A is chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ev_match_a | output | 1 | Slot A address-hit pulse |
| ev_match_b | output | 1 | Slot B address-hit pulse |
| ev_rx_a | output | 1 | Slot A byte-received pulse |
| ev_rx_b | output | 1 | Slot B byte-received pulse |
| ev_tx_a | output | 1 | Slot A transmit register consumed pulse |
| ev_tx_b | output | 1 | Slot B transmit register consumed pulse |

## Verification
The bench builds the engine with a three-stage synchronizer and with reset addresses 0x50 for slot A and 0x3A for slot B, both different from the defaults. The reset check can therefore tell real parameter use from hard-coded values. Because these addresses are live straight after reset, the transfer table can hit all four members of slot A's group, near misses on both slots, and then a reprogrammed slot B that overlaps group A to exercise the priority rule. The deeper synchronizer adds one cycle of latency, which shows that the acknowledge and data timing hold with slack within the bench's SCL quarter period.

// File: rtl/dual_addr_i2c_slave.sv
module dual_addr_i2c_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] RST_ADDR_A  = 7'h10,
  parameter logic [6:0] RST_ADDR_B  = 7'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       ev_match_a,
  output logic       ev_match_b,
  output logic       ev_rx_a,
  output logic       ev_rx_b,
  output logic       ev_tx_a,
  output logic       ev_tx_b
);

  localparam logic [2:0] RA_CTRL = 3'd0, RA_ADR_A = 3'd1, RA_ADR_B = 3'd2,
                         RA_BUF_A = 3'd3, RA_BUF_B = 3'd4, RA_STAT = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK_DRV, S_ACK_HOLD, S_RX, S_TX, S_TX_ACK, S_TX_LOAD
  } st_t;

  st_t state;
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [1:0] en;
  logic [6:0] addr_a, addr_b;
  logic [7:0] tx_a, tx_b, rx_a, rx_b, sh, tx_cur;
  logic [2:0] cnt;
  logic [1:0] lsb_a;
  logic busy, dir, nack_in, wa_a, wa_b, sel_b, first;
  logic hit_a, hit_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end

  assign scl_s     = scl_sync[SYNC_STAGES-1];
  assign sda_s     = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign hit_a  = en[0] && (sh[6:2] == addr_a[6:2]);
  assign hit_b  = en[1] && (sh[6:0] == addr_b);
  assign tx_cur = sel_b ? tx_b : tx_a;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      en <= '0; addr_a <= RST_ADDR_A; addr_b <= RST_ADDR_B;
      tx_a <= '0; tx_b <= '0; rx_a <= '0; rx_b <= '0; sh <= '0;
      cnt <= '0; lsb_a <= '0;
      busy <= 1'b0; dir <= 1'b0; nack_in <= 1'b0; wa_a <= 1'b0; wa_b <= 1'b0;
      sel_b <= 1'b0; first <= 1'b0; sda_oe <= 1'b0;
      ev_match_a <= 1'b0; ev_match_b <= 1'b0; ev_rx_a <= 1'b0;
      ev_rx_b <= 1'b0; ev_tx_a <= 1'b0; ev_tx_b <= 1'b0;
    end else begin
      ev_match_a <= 1'b0; ev_match_b <= 1'b0; ev_rx_a <= 1'b0;
      ev_rx_b <= 1'b0; ev_tx_a <= 1'b0; ev_tx_b <= 1'b0;
      if (reg_we)
        case (reg_addr)
          RA_CTRL:  en     <= reg_wdata[1:0];
          RA_ADR_A: addr_a <= reg_wdata[7:1];
          RA_ADR_B: addr_b <= reg_wdata[7:1];
          RA_BUF_A: tx_a   <= reg_wdata;
          RA_BUF_B: tx_b   <= reg_wdata;
          default: ;
        endcase
      if (start_det) begin
        busy <= 1'b1; state <= S_ADDR; cnt <= '0; nack_in <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        busy <= 1'b0; state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR: if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (hit_a || hit_b) begin
                sel_b <= ~hit_a;
                if (hit_a) lsb_a <= sh[1:0];
                ev_match_a <= hit_a;
                ev_match_b <= ~hit_a;
                dir   <= sda_s;
                first <= 1'b1;
                state <= S_ACK_DRV;
              end else
                state <= S_IDLE;
            end
          end
          S_ACK_DRV: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= S_ACK_HOLD;
          end
          S_ACK_HOLD: if (scl_fall) begin
            cnt <= '0;
            if (dir) begin
              sh <= {tx_cur[6:0], 1'b0};
              sda_oe <= ~tx_cur[7];
              ev_tx_a <= ~sel_b;
              ev_tx_b <= sel_b;
              state <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
          S_RX: if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (sel_b) begin
                rx_b <= {sh[6:0], sda_s}; wa_b <= first; ev_rx_b <= 1'b1;
              end else begin
                rx_a <= {sh[6:0], sda_s}; wa_a <= first; ev_rx_a <= 1'b1;
              end
              first <= 1'b0;
              state <= S_ACK_DRV;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= S_TX_ACK;
            end else begin
              sda_oe <= ~sh[7];
              sh     <= {sh[6:0], 1'b0};
              cnt    <= cnt + 3'd1;
            end
          end
          S_TX_ACK: if (scl_rise) begin
            if (sda_s) begin
              nack_in <= 1'b1;
              state   <= S_IDLE;
            end else
              state <= S_TX_LOAD;
          end
          S_TX_LOAD: if (scl_fall) begin
            cnt <= '0;
            sh <= {tx_cur[6:0], 1'b0};
            sda_oe <= ~tx_cur[7];
            ev_tx_a <= ~sel_b;
            ev_tx_b <= sel_b;
            state <= S_TX;
          end
          default: ;
        endcase
      end
    end

  always_comb
    case (reg_addr)
      RA_CTRL:  reg_rdata = {6'd0, en};
      RA_ADR_A: reg_rdata = {addr_a, 1'b0};
      RA_ADR_B: reg_rdata = {addr_b, 1'b0};
      RA_BUF_A: reg_rdata = rx_a;
      RA_BUF_B: reg_rdata = rx_b;
      RA_STAT:  reg_rdata = {sel_b, lsb_a, wa_b, wa_a, nack_in, dir, busy};
      default:  reg_rdata = 8'd0;
    endcase

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  p_busy_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);
  p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
  p_sda_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !stop_det) |=> $stable(sda_oe));
  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_in) |-> !sda_oe);
  p_match_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_match_a, ev_match_b}));
  p_rx_ack_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_a || ev_rx_b) |-> (state == S_ACK_DRV));

endmodule

// File: tb/dual_addr_i2c_slave_tb_top.sv
module dual_addr_i2c_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, host_sda = 1'b1;
  logic sda_oe, sda_bus;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic ev_match_a, ev_match_b, ev_rx_a, ev_rx_b, ev_tx_a, ev_tx_b;
  int checks = 0, errors = 0;
  int n_ma = 0, n_mb = 0, n_ra = 0, n_rb = 0, n_ta = 0, n_tb = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = host_sda & ~sda_oe;

  dual_addr_i2c_slave #(.SYNC_STAGES(3), .RST_ADDR_A(7'h50), .RST_ADDR_B(7'h3A)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_match_a(ev_match_a), .ev_match_b(ev_match_b), .ev_rx_a(ev_rx_a),
    .ev_rx_b(ev_rx_b), .ev_tx_a(ev_tx_a), .ev_tx_b(ev_tx_b));

  always @(negedge clk) begin
    if (ev_match_a) n_ma++;
    if (ev_match_b) n_mb++;
    if (ev_rx_a) n_ra++;
    if (ev_rx_b) n_rb++;
    if (ev_tx_a) n_ta++;
    if (ev_tx_b) n_tb++;
  end

  // {address[6:0], data[7:0], expect ack, slot: 0 none / 1 A / 2 B}
  localparam logic [17:0] VEC [0:5] = '{
    {7'h3A, 8'hC5, 1'b1, 2'd2},
    {7'h51, 8'h96, 1'b1, 2'd1},
    {7'h53, 8'h0F, 1'b1, 2'd1},
    {7'h3B, 8'h77, 1'b0, 2'd0},
    {7'h54, 8'h11, 1'b0, 2'd0},
    {7'h50, 8'hE1, 1'b1, 2'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic i2c_start;
    host_sda = 1'b1; wq; scl = 1'b1; wq; host_sda = 1'b0; wq; scl = 1'b0; wq;
  endtask

  task automatic i2c_stop;
    host_sda = 1'b0; wq; scl = 1'b1; wq; host_sda = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq; scl = 1'b1; wq; scl = 1'b0; wq;
    end
    host_sda = 1'b1; wq; scl = 1'b1; wq; ack = ~sda_bus; scl = 1'b0; wq;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    host_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      scl = 1'b1; wq; d = {d[6:0], sda_bus}; scl = 1'b0; wq;
    end
    host_sda = nack; wq; scl = 1'b1; wq; scl = 1'b0; wq; host_sda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, exp_a, exp_b;
    logic ack;
    int ma0, mb0, t0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    rd(3'd5, d); chk("R1 status", d, 8'h00);
    rd(3'd0, d); chk("R1 control", d, 8'h00);
    rd(3'd1, d); chk("R1 addr A", d, 8'hA0);
    rd(3'd2, d); chk("R1 addr B", d, 8'h74);

    wr(3'd0, 8'h03);
    exp_a = 8'h00; exp_b = 8'h00;

    // table of single-byte writes: R3 R4 R5 R6 R7 R11 R2
    for (int i = 0; i < 6; i++) begin
      ma0 = n_ma; mb0 = n_mb;
      i2c_start;
      rd(3'd5, d); chk("R2 busy after START", d[0], 1);
      send_byte({VEC[i][17:11], 1'b0}, ack);
      chk("R3/R5 address ack", ack, VEC[i][2]);
      chk("R11 match A pulses", n_ma - ma0, (VEC[i][1:0] == 2'd1) ? 1 : 0);
      chk("R11 match B pulses", n_mb - mb0, (VEC[i][1:0] == 2'd2) ? 1 : 0);
      send_byte(VEC[i][10:3], ack);
      chk("R3/R5 data ack", ack, VEC[i][2]);
      i2c_stop;
      rd(3'd5, d); chk("R2 busy after STOP", d[0], 0);
      if (VEC[i][1:0] == 2'd1) exp_a = VEC[i][10:3];
      if (VEC[i][1:0] == 2'd2) exp_b = VEC[i][10:3];
      rd(3'd3, d); chk("R4/R5 rx A", d, exp_a);
      rd(3'd4, d); chk("R3/R5 rx B", d, exp_b);
      if (VEC[i][1:0] != 2'd0) begin
        rd(3'd5, d);
        chk("R7 direction write", d[1], 0);
        chk("R11 selected slot", d[7], VEC[i][1:0] == 2'd2);
        chk("R6 word address flag", VEC[i][1:0] == 2'd1 ? d[3] : d[4], 1);
        if (VEC[i][1:0] == 2'd1) chk("R4 low address bits", d[6:5], VEC[i][12:11]);
      end
    end

    // R6 first byte vs second byte
    i2c_start; send_byte({7'h3A, 1'b0}, ack);
    send_byte(8'h10, ack);
    rd(3'd5, d); chk("R6 first byte flag B", d[4], 1);
    rd(3'd4, d); chk("R6 rx B first", d, 8'h10);
    send_byte(8'h20, ack);
    rd(3'd5, d); chk("R6 second byte flag B", d[4], 0);
    rd(3'd4, d); chk("R3 rx B second", d, 8'h20);
    i2c_stop;
    exp_b = 8'h20;

    // R8 R9 R7 slave transmit from B
    wr(3'd4, 8'hA5);
    t0 = n_tb;
    i2c_start; send_byte({7'h3A, 1'b1}, ack);
    chk("R8 read address ack", ack, 1);
    rd(3'd5, d); chk("R7 direction read", d[1], 1);
    wr(3'd4, 8'h3C);
    recv_byte(1'b0, d); chk("R8 first tx byte", d, 8'hA5);
    recv_byte(1'b1, d); chk("R8 second tx byte", d, 8'h3C);
    chk("R8 tx event count", n_tb - t0, 2);
    rd(3'd5, d); chk("R9 nack status", d[2], 1);
    chk("R9 sda released", sda_oe, 0);
    i2c_stop;
    i2c_start;
    rd(3'd5, d); chk("R9 nack cleared by START", d[2], 0);
    i2c_stop;

    // R10 repeated start
    i2c_start; send_byte({7'h3A, 1'b0}, ack); send_byte(8'h44, ack);
    i2c_start;
    rd(3'd5, d); chk("R10 busy over repeated START", d[0], 1);
    send_byte({7'h52, 1'b0}, ack); chk("R10 address after repeated START", ack, 1);
    send_byte(8'h99, ack);
    i2c_stop;
    rd(3'd3, d); chk("R10 rx A", d, 8'h99);
    rd(3'd4, d); chk("R10 rx B", d, 8'h44);
    rd(3'd5, d); chk("R4 low bits after repeat", d[6:5], 2'b10);
    exp_a = 8'h99; exp_b = 8'h44;

    // R5 disabled slot
    wr(3'd0, 8'h01);
    mb0 = n_mb;
    i2c_start; send_byte({7'h3A, 1'b0}, ack);
    chk("R5 disabled no ack", ack, 0);
    send_byte(8'h55, ack); chk("R5 disabled data no ack", ack, 0);
    i2c_stop;
    rd(3'd4, d); chk("R5 disabled rx B kept", d, exp_b);
    chk("R5 disabled no match event", n_mb - mb0, 0);

    // R12 overlap: A wins
    wr(3'd0, 8'h03);
    wr(3'd2, 8'hA2);
    ma0 = n_ma; mb0 = n_mb;
    i2c_start; send_byte({7'h51, 1'b0}, ack);
    chk("R12 overlap ack", ack, 1);
    send_byte(8'h5A, ack);
    i2c_stop;
    rd(3'd3, d); chk("R12 rx A gets byte", d, 8'h5A);
    rd(3'd4, d); chk("R12 rx B unchanged", d, exp_b);
    chk("R12 match A", n_ma - ma0, 1);
    chk("R12 no match B", n_mb - mb0, 0);
    rd(3'd5, d); chk("R12 slot A selected", d[7], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule